// File: doc/BRIEF.md
# Detector readout stream parser

This block walks a stream of 32-bit readout words, one per accepted handshake, that a front-end crate produces for each event. It frames each event with a start flag on the first word, an end flag on the last word, and a word count given with the first word. Inside the event it finds module header groups and records their trigger number, beam clock and physical module id, one slot per logical module. It then follows the ADC sample runs of each channel and turns every accepted sample into a write on an external sample memory port. Trailer words close a module and send the parser back to look for the next header.

The block resynchronizes after unknown words with a bounded search. If the header test fails, the whole event is marked as aborted and its header results are dropped. A static mode pin selects 3 or 24 samples per channel, and this choice sets the sample memory layout. The memory is outside the block.

Top module: `readout_parser`

## Requirements
- R1: Before each header test, up to 10 words whose bits [31:28] are not 4'h8 are consumed and ignored. The word that follows these (or the first word with top nibble 4'h8) is then tested as a header.
- R2: A word is a header when `(w & 32'hF00FF000) == 32'h800FF000`. Any other word at the header test aborts the event. At `done`, `abort` is 1, `mod_count` is 0 and every header slot reads 0.
- R3: A header group is four consecutive words. Word 0 bits [3:0] give the logical module L. Word 1 bits [11:0] go to slot L of `hdr_trig`, word 2 bits [11:0] to slot L of `hdr_bclk`, and word 3 bits [4:0] to slot L of `hdr_pmid`. Slot L is bits [12L+11:12L], or [5L+4:5L] for `hdr_pmid`.
- R4: A logical module of 4 or more sets `lmod_err` and stores no header fields. `mod_count` still counts every valid header.
- R5: A first-sample word satisfies `(w & 32'hF0002000) == 32'h40002000`. Its ADC value is in bits [11:0], its channel in bits [21:16] and its module in bits [23:22]. It writes sample index 0. A write appears on `wr_en`/`wr_addr`/`wr_data` in the cycle after the word is accepted.
- R6: A continuation word satisfies `(w & 32'hF0002000) == 32'h40000000`. It is taken as the next sample only while its channel and module equal those of the run's first-sample word. Any other word ends the run and is evaluated again without being consumed.
- R7: The write address is 48·N·module + N·channel + sample index. N is 24 when `mode24` = 1 and 3 when `mode24` = 0.
- R8: Samples with index N or higher in a run are consumed but not written.
- R9: After a run, or right after a header, a word with top nibble 4'h2 is a trailer. It is consumed, and the next word goes to header search. Any other word that is neither a sample nor a trailer goes straight to header search.
- R10: A header search does not start when the word's position in the event plus 10 is at least the event length. The remaining words are consumed without effect.
- R11: The start flag clears the header slots, `mod_count`, `lmod_err` and `abort`. `done` pulses for one cycle in the cycle after the end-flagged word is accepted, and `abort` is valid during that pulse.
- R12: `in_ready` is low only in a cycle in which a word ends a sample run, and is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode24 | input | 1 | Static samples-per-channel select: 1 = 24, 0 = 3 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Parser accepts the word this cycle |
| in_data | input | 32 | Readout word |
| in_sof | input | 1 | Word is the first of an event |
| in_eof | input | 1 | Word is the last of an event |
| in_len | input | 16 | Event length in words, valid with `in_sof` |
| wr_en | output | 1 | Sample memory write strobe |
| wr_addr | output | 13 | Sample memory address |
| wr_data | output | 12 | ADC value to write |
| hdr_trig | output | 48 | Trigger number, 12 bits per logical module |
| hdr_bclk | output | 48 | Beam clock, 12 bits per logical module |
| hdr_pmid | output | 20 | Physical module id, 5 bits per logical module |
| mod_count | output | 8 | Valid headers seen in the current event |
| lmod_err | output | 1 | A logical module number of 4 or more was seen |
| abort | output | 1 | Event failed the header test |
| done | output | 1 | One-cycle end-of-event pulse |

## Verification
Some properties are checked on every cycle: each write follows an accepted word by one cycle, every address stays inside the memory size for the selected mode, a stall lasts only one cycle, and `done` follows an accepted end-flagged word. An aborted event must show a zero count and empty header slots at `done`. Other behaviour depends on what came earlier in the stream, and only the bench scenarios can show it. This covers where the skip limit falls, the suppression of writes past N, the channel-mismatch stall landing on the right word, the tail cutoff, and header slots being skipped for out-of-range module numbers.

// File: rtl/readout_parser.sv
module readout_parser #(
  parameter int MAX_MOD  = 4,
  parameter int CHANNELS = 48,
  parameter int SKIP_MAX = 10,
  parameter int TAIL     = 10,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode24,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [31:0]           in_data,
  input  logic                  in_sof,
  input  logic                  in_eof,
  input  logic [LEN_W-1:0]      in_len,
  output logic                  wr_en,
  output logic [12:0]           wr_addr,
  output logic [11:0]           wr_data,
  output logic [12*MAX_MOD-1:0] hdr_trig,
  output logic [12*MAX_MOD-1:0] hdr_bclk,
  output logic [5*MAX_MOD-1:0]  hdr_pmid,
  output logic [CNT_W-1:0]      mod_count,
  output logic                  lmod_err,
  output logic                  abort,
  output logic                  done
);
  localparam int N_HI = 24;
  localparam int N_LO = 3;
  localparam int SKW  = $clog2(SKIP_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SRCH, S_H1, S_H2, S_H3, S_SAMP, S_RUN, S_DRAIN} st_t;

  st_t              st_q, b_st, e_st;
  logic [LEN_W-1:0] pos_q, len_q, c_pos, c_len;
  logic [SKW-1:0]   skip_q, c_skip;
  logic [3:0]       lmod_q;
  logic [5:0]       fch_q, a_ch;
  logic [1:0]       fmod_q, a_mod;
  logic [4:0]       idx_q, a_idx, n_smp;
  logic [CNT_W-1:0] cnt_b;
  logic [11:0]      trig_q [MAX_MOD];
  logic [11:0]      bclk_q [MAX_MOD];
  logic [4:0]       pmid_q [MAX_MOD];
  logic             acc, is_hdr, is_first, is_cont, is_trl, same, tail_stop, lmod_ok;
  logic [12:0]      addr_c;

  assign is_hdr   = (in_data & 32'hF00FF000) == 32'h800FF000;
  assign is_first = (in_data & 32'hF0002000) == 32'h40002000;
  assign is_cont  = (in_data & 32'hF0002000) == 32'h40000000;
  assign is_trl   = in_data[31:28] == 4'h2;
  assign same     = in_data[21:16] == fch_q && in_data[23:22] == fmod_q;

  assign b_st   = in_sof ? S_SRCH : st_q;
  assign e_st   = (b_st == S_SAMP && !is_first && !is_trl) ? S_SRCH : b_st;
  assign c_pos  = in_sof ? '0 : pos_q;
  assign c_len  = in_sof ? in_len : len_q;
  assign c_skip = in_sof ? '0 : skip_q;
  assign cnt_b  = in_sof ? '0 : mod_count;

  assign in_ready = !(in_valid && e_st == S_RUN && !(is_cont && same));
  assign acc      = in_valid && in_ready;

  assign tail_stop = ({1'b0, c_pos} + (LEN_W+1)'(TAIL)) >= {1'b0, c_len};
  assign lmod_ok   = lmod_q < 4'(MAX_MOD);
  assign n_smp     = mode24 ? 5'(N_HI) : 5'(N_LO);

  assign a_mod  = (e_st == S_RUN) ? fmod_q : in_data[23:22];
  assign a_ch   = (e_st == S_RUN) ? fch_q  : in_data[21:16];
  assign a_idx  = (e_st == S_RUN) ? idx_q  : 5'd0;
  assign addr_c = 13'(int'(a_mod) * CHANNELS * int'(n_smp) + int'(a_ch) * int'(n_smp) + int'(a_idx));

  for (genvar g = 0; g < MAX_MOD; g++) begin : g_slot
    assign hdr_trig[12*g +: 12] = trig_q[g];
    assign hdr_bclk[12*g +: 12] = bclk_q[g];
    assign hdr_pmid[5*g +: 5]   = pmid_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; pos_q <= '0; len_q <= '0; skip_q <= '0; lmod_q <= '0;
      fch_q <= '0; fmod_q <= '0; idx_q <= '0; mod_count <= '0;
      lmod_err <= 1'b0; abort <= 1'b0; done <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      for (int m = 0; m < MAX_MOD; m++) begin
        trig_q[m] <= '0; bclk_q[m] <= '0; pmid_q[m] <= '0;
      end
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (acc) begin
        if (in_sof) begin
          mod_count <= '0; lmod_err <= 1'b0; abort <= 1'b0;
          for (int m = 0; m < MAX_MOD; m++) begin
            trig_q[m] <= '0; bclk_q[m] <= '0; pmid_q[m] <= '0;
          end
        end
        pos_q <= c_pos + 1'b1;
        len_q <= c_len;
        case (e_st)
          S_SRCH: begin
            if (c_skip == '0 && tail_stop) begin
              st_q <= S_DRAIN;
            end else if (in_data[31:28] != 4'h8 && c_skip < SKW'(SKIP_MAX)) begin
              skip_q <= c_skip + 1'b1;
              st_q   <= S_SRCH;
            end else if (is_hdr) begin
              skip_q    <= '0;
              mod_count <= cnt_b + 1'b1;
              lmod_q    <= in_data[3:0];
              if (in_data[3:0] >= 4'(MAX_MOD)) lmod_err <= 1'b1;
              st_q <= S_H1;
            end else begin
              skip_q    <= '0;
              abort     <= 1'b1;
              mod_count <= '0;
              for (int m = 0; m < MAX_MOD; m++) begin
                trig_q[m] <= '0; bclk_q[m] <= '0; pmid_q[m] <= '0;
              end
              st_q <= S_DRAIN;
            end
          end
          S_H1: begin
            if (lmod_ok) trig_q[lmod_q[1:0]] <= in_data[11:0];
            st_q <= S_H2;
          end
          S_H2: begin
            if (lmod_ok) bclk_q[lmod_q[1:0]] <= in_data[11:0];
            st_q <= S_H3;
          end
          S_H3: begin
            if (lmod_ok) pmid_q[lmod_q[1:0]] <= in_data[4:0];
            st_q <= S_SAMP;
          end
          S_SAMP: begin
            if (is_first) begin
              fch_q  <= in_data[21:16];
              fmod_q <= in_data[23:22];
              idx_q  <= 5'd1;
              wr_en  <= 1'b1; wr_addr <= addr_c; wr_data <= in_data[11:0];
              st_q   <= S_RUN;
            end else begin
              skip_q <= '0;
              st_q   <= S_SRCH;
            end
          end
          S_RUN: begin
            if (idx_q < n_smp) begin
              idx_q <= idx_q + 1'b1;
              wr_en <= 1'b1; wr_addr <= addr_c; wr_data <= in_data[11:0];
            end
          end
          default: ;
        endcase
        if (in_eof) begin
          st_q <= S_IDLE;
          done <= 1'b1;
        end
      end else if (in_valid) begin
        st_q <= S_SAMP;
      end
    end
  end
endmodule

// File: rtl/readout_parser_chk.sv
module readout_parser_chk #(
  parameter int MAX_MOD  = 4,
  parameter int CHANNELS = 48,
  parameter int CNT_W    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mode24,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  in_eof,
  input logic                  wr_en,
  input logic [12:0]           wr_addr,
  input logic [12*MAX_MOD-1:0] hdr_trig,
  input logic [12*MAX_MOD-1:0] hdr_bclk,
  input logic [5*MAX_MOD-1:0]  hdr_pmid,
  input logic [CNT_W-1:0]      mod_count,
  input logic                  abort,
  input logic                  done
);
  localparam int LIM_HI = CHANNELS * 24 * MAX_MOD;
  localparam int LIM_LO = CHANNELS * 3 * MAX_MOD;

  // R12
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> in_ready);

  // R5
  wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid && in_ready));

  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < (mode24 ? LIM_HI : LIM_LO)));

  // R11
  done_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_ready && in_eof));

  // R2
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && abort) |-> (mod_count == '0 && hdr_trig == '0 && hdr_bclk == '0 && hdr_pmid == '0));
endmodule

bind readout_parser readout_parser_chk #(.MAX_MOD(MAX_MOD), .CHANNELS(CHANNELS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode24(mode24), .in_valid(in_valid), .in_ready(in_ready),
  .in_eof(in_eof), .wr_en(wr_en), .wr_addr(wr_addr), .hdr_trig(hdr_trig), .hdr_bclk(hdr_bclk),
  .hdr_pmid(hdr_pmid), .mod_count(mod_count), .abort(abort), .done(done)
);

// File: tb/readout_parser_bench.sv
module readout_parser_bench;
  logic        clk = 0, rst_n = 0, mode24 = 0;
  logic        in_valid = 0, in_sof = 0, in_eof = 0;
  logic [31:0] in_data = '0;
  logic [15:0] in_len = '0;
  logic        in_ready, wr_en, lmod_err, abort, done;
  logic [12:0] wr_addr;
  logic [11:0] wr_data;
  logic [47:0] hdr_trig, hdr_bclk;
  logic [19:0] hdr_pmid;
  logic [7:0]  mod_count;

  readout_parser u_readout_parser (
    .clk(clk), .rst_n(rst_n), .mode24(mode24), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_len(in_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .hdr_trig(hdr_trig),
    .hdr_bclk(hdr_bclk), .hdr_pmid(hdr_pmid), .mod_count(mod_count),
    .lmod_err(lmod_err), .abort(abort), .done(done)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] ev[$];
  int exp_wr[$];
  bit stall_at[int];
  int e_cnt, e_abort, e_err;
  int e_trig[4], e_bclk[4], e_pmid[4];

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(int p);
    return (p < ev.size()) ? ev[p] : 32'h0;
  endfunction

  function automatic logic [31:0] hd0(int lm);  return 32'h800FF000 | 32'(lm); endfunction
  function automatic logic [31:0] fs(int ch, int md, int adc);
    return 32'h40002000 | (32'(md) << 22) | (32'(ch) << 16) | 32'(adc);
  endfunction
  function automatic logic [31:0] cs(int ch, int md, int adc);
    return 32'h40000000 | (32'(md) << 22) | (32'(ch) << 16) | 32'(adc);
  endfunction

  task automatic add_hdr(int lm, int tr, int bc, int pm);
    ev.push_back(hd0(lm)); ev.push_back(32'(tr)); ev.push_back(32'(bc)); ev.push_back(32'(pm));
  endtask

  task automatic add_pad(int k);
    for (int i = 0; i < k; i++) ev.push_back(32'h0);
  endtask

  task automatic model();
    int L, pos, n, lm, ch, md, idx, base;
    logic [31:0] w;
    L = ev.size(); pos = 0; n = mode24 ? 24 : 3;
    e_cnt = 0; e_abort = 0; e_err = 0;
    for (int m = 0; m < 4; m++) begin e_trig[m] = 0; e_bclk[m] = 0; e_pmid[m] = 0; end
    stall_at.delete();
    while (pos + 10 < L) begin
      for (int i = 0; i < 10; i++) begin
        w = wd(pos);
        if (w[31:28] != 4'h8) pos++; else break;
      end
      w = wd(pos);
      if ((w & 32'hF00FF000) != 32'h800FF000) begin
        e_abort = 1; e_cnt = 0;
        for (int m = 0; m < 4; m++) begin e_trig[m] = 0; e_bclk[m] = 0; e_pmid[m] = 0; end
        break;
      end
      e_cnt++;
      lm = int'(w[3:0]);
      if (lm < 4) begin
        e_trig[lm] = int'(wd(pos+1) & 32'hFFF);
        e_bclk[lm] = int'(wd(pos+2) & 32'hFFF);
        e_pmid[lm] = int'(wd(pos+3) & 32'h1F);
      end else e_err = 1;
      pos += 4;
      while ((wd(pos) & 32'hF0002000) == 32'h40002000) begin
        w = wd(pos); ch = int'(w[21:16]); md = int'(w[23:22]);
        base = 48*n*md + n*ch;
        exp_wr.push_back((base << 12) | int'(w[11:0]));
        pos++; idx = 1;
        while (1) begin
          w = wd(pos);
          if (!((w & 32'hF0002000) == 32'h40000000 && int'(w[21:16]) == ch && int'(w[23:22]) == md)) break;
          if (idx < n) exp_wr.push_back(((base + idx) << 12) | int'(w[11:0]));
          idx++; pos++;
        end
        if (pos < L) stall_at[pos] = 1;
      end
      w = wd(pos);
      if (w[31:28] == 4'h2) pos++;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_wr.size() == 0) chk(0, "R8 unexpected write", int'(wr_addr), -1);
      else begin
        int e;
        e = exp_wr.pop_front();
        // R7 address, R5 data
        chk(int'(wr_addr) == (e >> 12), "R7 address", int'(wr_addr), e >> 12);
        chk(int'(wr_data) == (e & 32'hFFF), "R5 data", int'(wr_data), e & 32'hFFF);
      end
    end
  end

  task automatic send_event(string tag);
    int L, i;
    bit stalled, rdy;
    model();
    L = ev.size(); i = 0; stalled = 0;
    @(posedge clk); #1;
    while (i < L) begin
      in_valid = 1; in_data = ev[i]; in_sof = (i == 0); in_eof = (i == L-1); in_len = 16'(L);
      @(negedge clk);
      rdy = in_ready;
      // R12 / R6 stall position
      chk(rdy == !(stall_at.exists(i) && !stalled), "R12 ready", int'(rdy), int'(!(stall_at.exists(i) && !stalled)));
      @(posedge clk); #1;
      if (rdy) begin i++; stalled = 0; end else stalled = 1;
    end
    in_valid = 0; in_sof = 0; in_eof = 0;
    @(negedge clk);
    chk(done == 1'b1, "R11 done", int'(done), 1);
    chk(int'(abort) == e_abort, "R2 abort", int'(abort), e_abort);
    chk(int'(mod_count) == e_cnt, "R4 count", int'(mod_count), e_cnt);
    chk(int'(lmod_err) == e_err, "R4 lmod_err", int'(lmod_err), e_err);
    for (int m = 0; m < 4; m++) begin
      chk(int'(hdr_trig[12*m +: 12]) == e_trig[m], "R3 trig", int'(hdr_trig[12*m +: 12]), e_trig[m]);
      chk(int'(hdr_bclk[12*m +: 12]) == e_bclk[m], "R3 bclk", int'(hdr_bclk[12*m +: 12]), e_bclk[m]);
      chk(int'(hdr_pmid[5*m +: 5]) == e_pmid[m], "R3 pmid", int'(hdr_pmid[5*m +: 5]), e_pmid[m]);
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 done pulse", int'(done), 0);
    chk(exp_wr.size() == 0, "R5 missing writes", exp_wr.size(), 0);
    if (tag.len() == 0) $display("event done");
    ev.delete();
  endtask

  task automatic do_reset(bit m);
    rst_n = 0; mode24 = m;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1'b1 && done == 1'b0 && wr_en == 1'b0, "R11 reset outputs", int'({in_ready, done, wr_en}), 3'b100);
    chk(mod_count == 0 && abort == 0 && hdr_trig == 0, "R11 reset state", int'(mod_count), 0);
  endtask

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset(0);
    // R3 R5 R6 R8 R9 R1: runs, overflow, mismatch stall, skips
    add_hdr(0, 'h123, 'h456, 'h11);
    ev.push_back(fs(5, 0, 'hA1)); ev.push_back(cs(5, 0, 'hA2)); ev.push_back(cs(5, 0, 'hA3));
    ev.push_back(fs(6, 1, 'hB1));
    for (int k = 0; k < 4; k++) ev.push_back(cs(6, 1, 'hB2 + k));
    ev.push_back(cs(7, 1, 'hC0));
    ev.push_back(32'h20000000); ev.push_back(32'h12345678);
    add_hdr(2, 'h0AB, 'hCDE, 'h1F);
    ev.push_back(fs(47, 3, 'hFFF)); ev.push_back(32'h20000000);
    add_pad(10);
    send_event("r1_runs");
    // R2 abort on bad header test
    add_hdr(1, 'h111, 'h222, 'h3);
    ev.push_back(fs(0, 0, 'h5)); ev.push_back(32'h20000000); ev.push_back(32'h80000001);
    add_pad(10);
    send_event("r2_abort");
    // R4 out-of-range logical module
    add_hdr(5, 'h777, 'h888, 'h9);
    ev.push_back(fs(1, 2, 'h33)); ev.push_back(32'h20000000);
    add_hdr(3, 'h0F0, 'h00F, 'h4); ev.push_back(32'h20000000);
    add_pad(10);
    send_event("r4_lmod");
    // R1 exactly 10 skipped words then header
    for (int k = 0; k < 10; k++) ev.push_back(32'h10000000 + k);
    add_hdr(1, 'h321, 'h654, 'h7); ev.push_back(32'h20000000);
    add_pad(10);
    send_event("r1_ten");
    // R1 eleven skipped words abort
    for (int k = 0; k < 11; k++) ev.push_back(32'h10000000 + k);
    add_hdr(1, 'h321, 'h654, 'h7); ev.push_back(32'h20000000);
    add_pad(10);
    send_event("r1_eleven");
    // R10 tail cutoff
    add_hdr(0, 'h5, 'h6, 'h7); ev.push_back(32'h20000000);
    add_hdr(1, 'h8, 'h9, 'hA); add_pad(3);
    send_event("r10_tail");
    // R9 header then immediate trailer, R6 run ended by new first sample
    do_reset(1);
    // R7 mode 24 addressing, R8 suppression past 24
    add_hdr(3, 'hABC, 'hDEF, 'h15);
    ev.push_back(fs(47, 3, 'h100));
    for (int k = 0; k < 25; k++) ev.push_back(cs(47, 3, 'h200 + k));
    ev.push_back(fs(0, 0, 'h9)); ev.push_back(cs(0, 0, 'hA));
    ev.push_back(32'h20000000);
    add_hdr(0, 'h1, 'h2, 'h3); ev.push_back(32'h20000000);
    add_pad(10);
    send_event("r7_mode24");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule